// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register storage of a small 32-bit RISC core. Software sees sixteen general registers, a current status word and, in the five exception modes, a saved copy of that status word. Behind some register numbers sit several physical copies. The current processor mode, held in the low five bits of the status word, picks which copy a register number reaches. Altogether there are 31 physical general registers, one current status register and five saved-status registers. That is 37 storage words, of which 20 are reachable only in one particular mode.

Two combinational read ports and one clocked write port serve the general registers. The status word can be written directly. A direct write may change the mode, but it never touches any saved status. A separate exception-entry strobe does three things in one edge: it copies the status word into the target mode's saved-status register, switches the mode and masks the normal interrupt. Decode, execution and the pipeline stay outside the block and drive these ports.

Top module: `bank_regfile`

## Requirements
- R1: After reset the status word is 0x000000D3 (supervisor mode 10011 in bits [4:0], bits 7 and 6 set). Every general register and every saved-status register reads zero.
- R2: Register numbers 0 to 7 and 15 each have a single physical copy, shared by every mode.
- R3: In FIQ mode (10001), register numbers 8 to 14 reach seven copies private to that mode. All other modes reach one shared set for numbers 8 to 12.
- R4: Register numbers 13 and 14 have a private pair in each of IRQ (10010), supervisor (10011), abort (10111) and undefined (11011). User (10000), system (11111) and any unrecognised mode code share the user pair.
- R5: Both read ports return, in the same cycle, the copy selected by the current mode. A write lands at the clock edge, so a read of the same register in that cycle returns the old value. A write in the cycle of an exception entry goes to the bank of the mode in force before the entry.
- R6: When the exception strobe is high and the requested mode is one of the five exception codes, the target mode's saved status receives the status word. The status word then gets the new mode in [4:0] and bit 7 set. Bit 6 is set if the target is FIQ and kept otherwise. All other bits are kept. A request with any other mode code is ignored.
- R7: A direct status-word write never changes any saved-status register. An exception entry in the same cycle takes precedence over a direct status-word write.
- R8: In any mode other than user, a direct status-word write replaces the whole word. In user mode it changes only bits [31:28].
- R9: In user or system mode, the saved-status read port returns the status word and a saved-status write is ignored. In an exception mode, both reach that mode's own saved status. If an exception entry in the same cycle targets that same register, the copied status word wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Register number, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Register number, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | 32 | Write data |
| stat_wr_en | input | 1 | Direct status-word write enable |
| stat_wr_data | input | 32 | Direct status-word write data |
| saved_wr_en | input | 1 | Saved-status write enable (current mode) |
| saved_wr_data | input | 32 | Saved-status write data |
| saved_rd_data | output | 32 | Saved status of the current mode |
| exc_take | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Mode code entered on exception |
| stat_data | output | 32 | Current status word |

## Verification
Exception entry and direct status-word writes can land in the same cycle, and so can exception entry and saved-status writes. The bench drives an exception strobe together with a status-word write that asks for a different mode, and checks that the entry wins. It also checks that a general register write in that cycle lands in the old mode's bank. A saved-status write aimed at the slot that the same-cycle exception targets must lose to the copied status word. Each case is judged through the read ports once the bank has been switched back.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam int NUM_ARCH    = 16;
    localparam int NUM_FIQ_BNK = 7;
    localparam int NUM_PAIRS   = 4;
    localparam int NUM_PHYS    = NUM_ARCH + NUM_FIQ_BNK + 2 * NUM_PAIRS;
    localparam int PHYS_W      = $clog2(NUM_PHYS);
    localparam int NUM_SAVED   = NUM_PAIRS + 1;
    localparam int SLOT_W      = $clog2(NUM_SAVED);
    localparam int FIQ_BASE    = NUM_ARCH;
    localparam int PAIR_BASE   = NUM_ARCH + NUM_FIQ_BNK;

    localparam logic [4:0] MODE_USR = 5'b10000;
    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_SYS = 5'b11111;

    typedef struct packed {
        logic              valid;
        logic [SLOT_W-1:0] slot;
    } slot_t;

    // Pair order after the FIQ bank: IRQ, SVC, ABT, UND
    function automatic int pair_of(input logic [4:0] mode);
        case (mode)
            MODE_IRQ: return 0;
            MODE_SVC: return 1;
            MODE_ABT: return 2;
            MODE_UND: return 3;
            default:  return -1;
        endcase
    endfunction

    function automatic logic [PHYS_W-1:0] phys_index(input logic [4:0] mode,
                                                     input logic [3:0] ridx);
        int p;
        p = pair_of(mode);
        if (mode == MODE_FIQ && ridx >= 4'd8 && ridx <= 4'd14)
            return PHYS_W'(FIQ_BASE + int'(ridx) - 8);
        if (p >= 0 && (ridx == 4'd13 || ridx == 4'd14))
            return PHYS_W'(PAIR_BASE + 2 * p + int'(ridx) - 13);
        return PHYS_W'(ridx);
    endfunction

    function automatic slot_t saved_slot(input logic [4:0] mode);
        slot_t s;
        int    p;
        p = pair_of(mode);
        s.valid = 1'b0;
        s.slot  = '0;
        if (mode == MODE_FIQ) begin
            s.valid = 1'b1;
            s.slot  = SLOT_W'(NUM_PAIRS);
        end else if (p >= 0) begin
            s.valid = 1'b1;
            s.slot  = SLOT_W'(p);
        end
        return s;
    endfunction

endpackage

// File: rtl/brf_index_map.sv
module brf_index_map
    import brf_pkg::*;
(
    input  logic [4:0]        mode,
    input  logic [3:0]        ridx,
    output logic [PHYS_W-1:0] pidx
);
    always_comb begin
        pidx = phys_index(mode, ridx);
    end
endmodule

// File: rtl/brf_gpr_store.sv
module brf_gpr_store
    import brf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PHYS_W-1:0] wr_pidx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PHYS_W-1:0] rd_a_pidx,
    input  logic [PHYS_W-1:0] rd_b_pidx,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data
);
    typedef struct packed {
        logic [NUM_PHYS-1:0][DATA_W-1:0] regs;
    } gpr_st_t;

    gpr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && int'(wr_pidx) < NUM_PHYS)
            st_d.regs[wr_pidx] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_a_data = (int'(rd_a_pidx) < NUM_PHYS) ? st_q.regs[rd_a_pidx] : '0;
        rd_b_data = (int'(rd_b_pidx) < NUM_PHYS) ? st_q.regs[rd_b_pidx] : '0;
    end

    // R5: storage moves only on a write strobe
    p_hold_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));
endmodule

// File: rtl/brf_status.sv
module brf_status
    import brf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr_en,
    input  logic [DATA_W-1:0] stat_wr_data,
    input  logic              saved_wr_en,
    input  logic [DATA_W-1:0] saved_wr_data,
    input  logic              exc_take,
    input  logic [4:0]        exc_mode,
    output logic [DATA_W-1:0] stat_data,
    output logic [DATA_W-1:0] saved_rd_data
);
    localparam int FLAG_LO = DATA_W - 4;
    localparam logic [DATA_W-1:0] RST_STAT = {{(DATA_W-8){1'b0}}, 3'b110, MODE_SVC};

    typedef struct packed {
        logic [DATA_W-1:0]                 stat;
        logic [NUM_SAVED-1:0][DATA_W-1:0]  saved;
    } psr_st_t;

    psr_st_t st_d, st_q;
    slot_t   cur_s, tgt_s;
    logic    exc_ok;
    logic    priv;

    always_comb begin
        cur_s  = saved_slot(st_q.stat[4:0]);
        tgt_s  = saved_slot(exc_mode);
        exc_ok = exc_take && tgt_s.valid;
        priv   = (st_q.stat[4:0] != MODE_USR);

        st_d = st_q;
        if (saved_wr_en && cur_s.valid)
            st_d.saved[cur_s.slot] = saved_wr_data;
        if (exc_ok) begin
            st_d.saved[tgt_s.slot] = st_q.stat;
            st_d.stat[4:0]         = exc_mode;
            st_d.stat[7]           = 1'b1;
            st_d.stat[6]           = st_q.stat[6] | (exc_mode == MODE_FIQ);
        end else if (stat_wr_en) begin
            if (priv) st_d.stat = stat_wr_data;
            else      st_d.stat = {stat_wr_data[DATA_W-1:FLAG_LO], st_q.stat[FLAG_LO-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stat  <= RST_STAT;
            st_q.saved <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_data     = st_q.stat;
    assign saved_rd_data = cur_s.valid ? st_q.saved[cur_s.slot] : st_q.stat;

    // R6: exception entry saves the old word into the target slot
    p_exc_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_ok |=> st_q.saved[$past(tgt_s.slot)] == $past(st_q.stat));
    // R6: exception entry switches to the requested mode
    p_exc_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_ok |=> st_q.stat[4:0] == $past(exc_mode) && st_q.stat[7]);
    // R7: without exception or saved write, no saved register moves
    p_direct_no_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_take && !saved_wr_en) |=> $stable(st_q.saved));
    // R8: user-mode status write keeps everything below the flags
    p_user_flags_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_en && !exc_take && st_q.stat[4:0] == MODE_USR)
        |=> st_q.stat[FLAG_LO-1:0] == $past(st_q.stat[FLAG_LO-1:0]));
    // R9: saved write in a mode without saved status changes nothing
    p_saved_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (saved_wr_en && !exc_take && !cur_s.valid) |=> $stable(st_q.saved));
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
    import brf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stat_wr_en,
    input  logic [DATA_W-1:0] stat_wr_data,
    input  logic              saved_wr_en,
    input  logic [DATA_W-1:0] saved_wr_data,
    output logic [DATA_W-1:0] saved_rd_data,
    input  logic              exc_take,
    input  logic [4:0]        exc_mode,
    output logic [DATA_W-1:0] stat_data
);
    localparam int NUM_PORTS = 3;

    logic [4:0]                       cur_mode;
    logic [NUM_PORTS-1:0][3:0]        port_idx;
    logic [NUM_PORTS-1:0][PHYS_W-1:0] port_pidx;

    assign cur_mode = stat_data[4:0];
    assign port_idx = {wr_idx, rd_b_idx, rd_a_idx};

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_map
        brf_index_map u_map (
            .mode (cur_mode),
            .ridx (port_idx[g]),
            .pidx (port_pidx[g])
        );
    end

    brf_gpr_store #(.DATA_W(DATA_W)) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_pidx   (port_pidx[2]),
        .wr_data   (wr_data),
        .rd_a_pidx (port_pidx[0]),
        .rd_b_pidx (port_pidx[1]),
        .rd_a_data (rd_a_data),
        .rd_b_data (rd_b_data)
    );

    brf_status #(.DATA_W(DATA_W)) u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .stat_wr_en    (stat_wr_en),
        .stat_wr_data  (stat_wr_data),
        .saved_wr_en   (saved_wr_en),
        .saved_wr_data (saved_wr_data),
        .exc_take      (exc_take),
        .exc_mode      (exc_mode),
        .stat_data     (stat_data),
        .saved_rd_data (saved_rd_data)
    );

    // R2: low registers and r15 map straight through in every mode
    p_shared_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx < 4'd8 || rd_a_idx == 4'd15) |-> port_pidx[0] == PHYS_W'(rd_a_idx));
    // R3: r8..r12 reach the shared set outside FIQ mode
    p_fiq_only_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != MODE_FIQ && rd_b_idx >= 4'd8 && rd_b_idx <= 4'd12)
        |-> port_pidx[1] == PHYS_W'(rd_b_idx));
    // R9: modes without saved status see the status word on the saved port
    p_saved_alias_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_USR || cur_mode == MODE_SYS) |-> saved_rd_data == stat_data);
endmodule

// File: tb/bank_regfile_tb.sv
`timescale 1ns/1ps
module bank_regfile_tb;

    localparam logic [2:0] OP_WG = 3'd0, OP_CR = 3'd1, OP_WC = 3'd2, OP_EX = 3'd3,
                           OP_CC = 3'd4, OP_CS = 3'd5, OP_WS = 3'd6;

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  idx;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 54;
    localparam vec_t VECS [NV] = '{
        '{OP_CC, 4'd0,  32'h0,        32'h000000D3, 8'd1},  // R1 reset word
        '{OP_CR, 4'd0,  32'h0,        32'h0,        8'd1},  // R1
        '{OP_CS, 4'd0,  32'h0,        32'h0,        8'd1},  // R1
        '{OP_WG, 4'd0,  32'h11,       32'h0,        8'd0},
        '{OP_WG, 4'd13, 32'h5D0,      32'h0,        8'd0},
        '{OP_WG, 4'd14, 32'h5E0,      32'h0,        8'd0},
        '{OP_WG, 4'd8,  32'h800,      32'h0,        8'd0},
        '{OP_WG, 4'd15, 32'h150,      32'h0,        8'd0},
        '{OP_CR, 4'd13, 32'h0,        32'h5D0,      8'd4},  // R4
        '{OP_WC, 4'd0,  32'hD2,       32'h0,        8'd0},  // to IRQ
        '{OP_CC, 4'd0,  32'h0,        32'hD2,       8'd8},  // R8
        '{OP_CS, 4'd0,  32'h0,        32'h0,        8'd7},  // R7 no save
        '{OP_CR, 4'd13, 32'h0,        32'h0,        8'd4},  // R4
        '{OP_CR, 4'd0,  32'h0,        32'h11,       8'd2},  // R2
        '{OP_CR, 4'd8,  32'h0,        32'h800,      8'd3},  // R3
        '{OP_WG, 4'd13, 32'h1D0,      32'h0,        8'd0},
        '{OP_WC, 4'd0,  32'hD1,       32'h0,        8'd0},  // to FIQ
        '{OP_CR, 4'd8,  32'h0,        32'h0,        8'd3},  // R3
        '{OP_CR, 4'd13, 32'h0,        32'h0,        8'd3},  // R3
        '{OP_CR, 4'd0,  32'h0,        32'h11,       8'd2},  // R2
        '{OP_CR, 4'd15, 32'h0,        32'h150,      8'd2},  // R2
        '{OP_WG, 4'd8,  32'hF8,       32'h0,        8'd0},
        '{OP_WG, 4'd12, 32'hFC,       32'h0,        8'd0},
        '{OP_WC, 4'd0,  32'hDF,       32'h0,        8'd0},  // to SYS
        '{OP_CR, 4'd8,  32'h0,        32'h800,      8'd3},  // R3
        '{OP_CR, 4'd12, 32'h0,        32'h0,        8'd3},  // R3
        '{OP_CR, 4'd13, 32'h0,        32'h0,        8'd4},  // R4
        '{OP_CS, 4'd0,  32'h0,        32'hDF,       8'd9},  // R9 alias
        '{OP_WS, 4'd0,  32'h1234,     32'h0,        8'd0},
        '{OP_CS, 4'd0,  32'h0,        32'hDF,       8'd9},  // R9 ignored
        '{OP_WG, 4'd13, 32'hA0,       32'h0,        8'd0},
        '{OP_WC, 4'd0,  32'h10,       32'h0,        8'd0},  // to USR
        '{OP_CC, 4'd0,  32'h0,        32'h10,       8'd8},  // R8
        '{OP_CR, 4'd13, 32'h0,        32'hA0,       8'd4},  // R4
        '{OP_WC, 4'd0,  32'hF00000D3, 32'h0,        8'd0},
        '{OP_CC, 4'd0,  32'h0,        32'hF0000010, 8'd8},  // R8 flags only
        '{OP_EX, 4'd0,  32'h17,       32'h0,        8'd0},  // enter ABT
        '{OP_CC, 4'd0,  32'h0,        32'hF0000097, 8'd6},  // R6
        '{OP_CS, 4'd0,  32'h0,        32'hF0000010, 8'd6},  // R6
        '{OP_CR, 4'd13, 32'h0,        32'h0,        8'd4},  // R4
        '{OP_EX, 4'd0,  32'h11,       32'h0,        8'd0},  // enter FIQ
        '{OP_CC, 4'd0,  32'h0,        32'hF00000D1, 8'd6},  // R6
        '{OP_CS, 4'd0,  32'h0,        32'hF0000097, 8'd6},  // R6
        '{OP_CR, 4'd12, 32'h0,        32'hFC,       8'd3},  // R3
        '{OP_WS, 4'd0,  32'hAB,       32'h0,        8'd0},
        '{OP_CS, 4'd0,  32'h0,        32'hAB,       8'd9},  // R9
        '{OP_WC, 4'd0,  32'hD3,       32'h0,        8'd0},  // to SVC
        '{OP_CS, 4'd0,  32'h0,        32'h0,        8'd7},  // R7
        '{OP_CR, 4'd14, 32'h0,        32'h5E0,      8'd4},  // R4
        '{OP_WC, 4'd0,  32'hD7,       32'h0,        8'd0},  // to ABT
        '{OP_CS, 4'd0,  32'h0,        32'hF0000010, 8'd9},  // R9 kept
        '{OP_EX, 4'd0,  32'h10,       32'h0,        8'd0},  // bad target
        '{OP_CC, 4'd0,  32'h0,        32'hD7,       8'd6},  // R6 ignored
        '{OP_EX, 4'd0,  32'h1B,       32'h0,        8'd0}   // enter UND
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, saved_rd_data, stat_data;
    logic        wr_en = 1'b0, stat_wr_en = 1'b0, saved_wr_en = 1'b0, exc_take = 1'b0;
    logic [31:0] wr_data = '0, stat_wr_data = '0, saved_wr_data = '0;
    logic [4:0]  exc_mode = '0;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    bank_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
        .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data),
        .saved_rd_data(saved_rd_data),
        .exc_take(exc_take), .exc_mode(exc_mode), .stat_data(stat_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; stat_wr_en = 1'b0; saved_wr_en = 1'b0; exc_take = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        case (v.op)
            OP_WG: begin wr_en = 1'b1; wr_idx = v.idx; wr_data = v.data; end
            OP_WC: begin stat_wr_en = 1'b1; stat_wr_data = v.data; end
            OP_WS: begin saved_wr_en = 1'b1; saved_wr_data = v.data; end
            OP_EX: begin exc_take = 1'b1; exc_mode = v.data[4:0]; end
            OP_CR: begin
                rd_a_idx = v.idx; rd_b_idx = v.idx; #1;
                check({tag, " portA"}, rd_a_data, v.exp);
                check({tag, " portB"}, rd_b_data, v.exp);
            end
            OP_CC: begin #1; check({tag, " status"}, stat_data, v.exp); end
            OP_CS: begin #1; check({tag, " saved"}, saved_rd_data, v.exp); end
            default: ;
        endcase
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R6: UND entry from ABT 0xD7
        run_vec('{OP_CC, 4'd0, 32'h0, 32'hDB, 8'd6});
        run_vec('{OP_CS, 4'd0, 32'h0, 32'hD7, 8'd6});

        // R7 / R5: exception to IRQ, status write and GPR write in the same cycle
        @(negedge clk);
        exc_take = 1'b1; exc_mode = 5'b10010;
        stat_wr_en = 1'b1; stat_wr_data = 32'h13;
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h777;
        @(negedge clk);
        idle_inputs();
        #1;
        check("R7 exception beats status write", stat_data, 32'hD2);
        check("R6 irq saved", saved_rd_data, 32'hDB);
        rd_a_idx = 4'd13; #1;
        check("R5 irq r13 untouched", rd_a_data, 32'h1D0);
        run_vec('{OP_WC, 4'd0, 32'hDB, 32'h0, 8'd0});
        run_vec('{OP_CR, 4'd13, 32'h0, 32'h777, 8'd5});  // R5 old-mode bank

        // R9: same-cycle saved write and exception into the same slot
        @(negedge clk);
        exc_take = 1'b1; exc_mode = 5'b11011;
        saved_wr_en = 1'b1; saved_wr_data = 32'hAA;
        @(negedge clk);
        idle_inputs();
        #1;
        check("R9 exception copy wins", saved_rd_data, 32'hDB);

        // R5: read during the write cycle sees the old value
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd1; wr_data = 32'h42; rd_a_idx = 4'd1; #1;
        check("R5 read before edge", rd_a_data, 32'h0);
        @(negedge clk);
        idle_inputs(); #1;
        check("R5 read after edge", rd_a_data, 32'h42);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; #1;
        check("R1 status after reset", stat_data, 32'hD3);
        check("R1 r1 after reset", rd_a_data, 32'h0);
        check("R1 saved after reset", saved_rd_data, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule